// File: doc/BRIEF.md
# Hit-Filtered L0 Line Buffer

This block is a small direct-mapped line buffer that sits between a CPU port and an L1 cache. It has one line for each L1 set, and the two share the same set index. A line enters the buffer only after it has been found in L1. A line that had to come from main memory stays out of the buffer until a later access finds it in L1. Data touched once never displaces a line that is reused.

Every CPU request checks the buffer first. A read hit returns from the buffer in the next cycle and does not touch L1. On a buffer miss the request goes to L1. If L1 hits, L1 returns the whole line, the line is written into the buffer, and the requested word is then served from the buffer. If L1 misses, the word L1 returns is passed straight to the CPU and the buffer is not changed. A response flag selects the data source, acting as the CPU-side mux. A write that hits the buffer updates the buffer and is also forwarded to L1, so the two stay coherent. When L1 evicts or invalidates a line, it sends a notification, and any matching buffer entry is dropped.

Top module: `l0_hit_buffer`

## Requirements
- R1: After reset the buffer holds no valid line. `cpu_req_ready` is 1, `cpu_rsp_valid` is 0 and `l1_req_valid` is 0, so the first access to any line goes to L1.
- R2: A read that hits the buffer is answered in the cycle right after it is accepted. The response has `cpu_rsp_from_buf`=1, the stored word, and no L1 request.
- R3: A buffer miss that L1 reports as a hit (`l1_rsp_hit`=1) copies the returned line into the buffer, then answers with `cpu_rsp_from_buf`=1. Later accesses to that line hit the buffer.
- R4: A buffer miss that L1 reports as a miss (`l1_rsp_hit`=0) answers with `cpu_rsp_from_buf`=0 and the word L1 returned. The buffer is left unchanged, so the next access to that line goes to L1 again.
- R5: A write that hits the buffer updates the buffered word and sends one L1 request with `l1_req_we`=1 and the same address and data. It answers with `cpu_rsp_from_buf`=1 only after L1 responds.
- R6: A write that misses the buffer is forwarded to L1, which returns the line with the write already applied. On an L1 hit the line is buffered and the answer has `cpu_rsp_from_buf`=1. On an L1 miss the answer has `cpu_rsp_from_buf`=0.
- R7: A pulse on `l1_inv_valid` clears the buffer entry whose set and tag match `l1_inv_addr`. The same set with a different tag is not affected.
- R8: Word address bits [OFF_W-1:0] select the word within a line. The next IDX_W bits select the set, shared with L1. The remaining upper bits are the tag. Every set holds its own line at the same time as the others.
- R9: Only one request is in flight at a time. `cpu_req_ready` is 0 from the acceptance of a request that needs L1 until its response. Each such request makes exactly one single-cycle `l1_req_valid` pulse.
- R10: If an invalidation for a line arrives in the same cycle as the L1-hit fill of that line, the entry ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_rdata | output | DATA_W | Word at the requested address |
| cpu_rsp_from_buf | output | 1 | 1 = data taken from buffer, 0 = from L1 |
| l1_req_valid | output | 1 | One-cycle request to L1 |
| l1_req_we | output | 1 | L1 request is a write |
| l1_req_addr | output | ADDR_W | L1 request word address |
| l1_req_wdata | output | DATA_W | L1 write data |
| l1_rsp_valid | input | 1 | L1 response strobe |
| l1_rsp_hit | input | 1 | L1 found the line without main memory |
| l1_rsp_line | input | WORDS*DATA_W | Full line, word w at bits [w*DATA_W +: DATA_W] |
| l1_inv_valid | input | 1 | L1 dropped a line |
| l1_inv_addr | input | ADDR_W | Any word address in the dropped line |

## Verification
Cold reads, repeated reads and reads of other words in a filled line show the three paths apart: the L1 miss leaves the line unbuffered, the second read fills the buffer, and the third read returns in one cycle with no L1 traffic. Writes are tried against a buffered line, a line present only in L1, and an absent line; each case checks the source flag and the data seen at L1. Invalidations with a matching tag and with a foreign tag show that only the named line is dropped. A sweep over all sets shows that every set holds its own line. A fill that coincides with an invalidation of the same line shows that the invalidation wins.

// File: rtl/l0buf_pkg.sv
package l0buf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_SERVE
  } l0_state_e;

  localparam logic SRC_L1  = 1'b0;
  localparam logic SRC_BUF = 1'b1;

endpackage

// File: rtl/l0buf_store.sv
module l0buf_store #(
  parameter int SETS   = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5,
  parameter int IDX_W  = $clog2(SETS),
  parameter int OFF_W  = $clog2(WORDS),
  parameter int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [OFF_W-1:0]  lk_off,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_word,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic [TAG_W-1:0]  inv_tag
);

  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   vld_d;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS][WORDS];

  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_word = dat_q[lk_idx][lk_off];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             fill_here;
    logic             wr_here;
    logic             inv_here;
    logic [TAG_W-1:0] tag_eff;

    assign fill_here = fill_en && (fill_idx == IDX_W'(s));
    assign wr_here   = wr_en && (lk_idx == IDX_W'(s));
    assign tag_eff   = fill_here ? fill_tag : tag_q[s];
    assign inv_here  = inv_en && (inv_idx == IDX_W'(s)) && (inv_tag == tag_eff);

    always_comb begin
      vld_d[s] = vld_q[s];
      if (fill_here) vld_d[s] = 1'b1;
      if (inv_here)  vld_d[s] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[s] <= 1'b0;
      else        vld_q[s] <= vld_d[s];
    end

    always_ff @(posedge clk) begin
      if (fill_here) tag_q[s] <= fill_tag;
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic wr_word;
      assign wr_word = wr_here && (lk_off == OFF_W'(w));
      always_ff @(posedge clk) begin
        if (fill_here)    dat_q[s][w] <= fill_line[w*DATA_W +: DATA_W];
        else if (wr_word) dat_q[s][w] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/l0buf_ctrl.sv
module l0buf_ctrl
  import l0buf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  input  logic              lk_hit,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              wr_en,
  output logic              fill_en,
  input  logic              l1_rsp_valid,
  input  logic              l1_rsp_hit,
  output logic              l1_req_valid,
  output logic              l1_req_we,
  output logic [ADDR_W-1:0] l1_req_addr,
  output logic [DATA_W-1:0] l1_req_wdata,
  output logic              rsp_load,
  output logic              rsp_sel
);

  l0_state_e         st_q, st_d;
  logic              thru_q, thru_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;

  assign accept  = (st_q == ST_IDLE) && cpu_req_valid;
  assign lk_addr = (st_q == ST_IDLE) ? cpu_req_addr : addr_q;

  always_comb begin
    st_d     = st_q;
    thru_d   = thru_q;
    wr_en    = 1'b0;
    fill_en  = 1'b0;
    rsp_load = 1'b0;
    rsp_sel  = SRC_BUF;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          thru_d = lk_hit && cpu_req_we;
          if (lk_hit && !cpu_req_we) begin
            rsp_load = 1'b1;
          end else begin
            wr_en = lk_hit;
            st_d  = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (l1_rsp_valid) begin
          if (thru_q) begin
            rsp_load = 1'b1;
            st_d     = ST_IDLE;
          end else if (l1_rsp_hit) begin
            fill_en = 1'b1;
            st_d    = ST_SERVE;
          end else begin
            rsp_load = 1'b1;
            rsp_sel  = SRC_L1;
            st_d     = ST_IDLE;
          end
        end
      end
      ST_SERVE: begin
        rsp_load = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      thru_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      thru_q <= thru_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      we_q    <= cpu_req_we;
      addr_q  <= cpu_req_addr;
      wdata_q <= cpu_req_wdata;
    end
  end

  assign cpu_req_ready = (st_q == ST_IDLE);
  assign l1_req_valid  = (st_q == ST_ISSUE);
  assign l1_req_we     = we_q;
  assign l1_req_addr   = addr_q;
  assign l1_req_wdata  = wdata_q;

endmodule

// File: rtl/l0buf_rsp_mux.sv
module l0buf_rsp_mux #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int OFF_W  = $clog2(WORDS),
  parameter int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              sel,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] buf_word,
  input  logic [LINE_W-1:0] l1_line,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_src
);

  logic [DATA_W-1:0] l1_word;
  logic [DATA_W-1:0] pick;

  assign l1_word = l1_line[off*DATA_W +: DATA_W];
  assign pick    = sel ? buf_word : l1_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= load;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rsp_data <= pick;
      rsp_src  <= sel;
    end
  end

endmodule

// File: rtl/l0_hit_buffer.sv
module l0_hit_buffer #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic                    cpu_req_we,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [DATA_W-1:0]       cpu_req_wdata,
  output logic                    cpu_rsp_valid,
  output logic [DATA_W-1:0]       cpu_rsp_rdata,
  output logic                    cpu_rsp_from_buf,
  output logic                    l1_req_valid,
  output logic                    l1_req_we,
  output logic [ADDR_W-1:0]       l1_req_addr,
  output logic [DATA_W-1:0]       l1_req_wdata,
  input  logic                    l1_rsp_valid,
  input  logic                    l1_rsp_hit,
  input  logic [WORDS*DATA_W-1:0] l1_rsp_line,
  input  logic                    l1_inv_valid,
  input  logic [ADDR_W-1:0]       l1_inv_addr
);

  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = WORDS * DATA_W;

  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_word;
  logic              wr_en;
  logic              fill_en;
  logic              rsp_load;
  logic              rsp_sel;

  l0buf_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_we    (cpu_req_we),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_req_ready (cpu_req_ready),
    .lk_hit        (lk_hit),
    .lk_addr       (lk_addr),
    .wr_en         (wr_en),
    .fill_en       (fill_en),
    .l1_rsp_valid  (l1_rsp_valid),
    .l1_rsp_hit    (l1_rsp_hit),
    .l1_req_valid  (l1_req_valid),
    .l1_req_we     (l1_req_we),
    .l1_req_addr   (l1_req_addr),
    .l1_req_wdata  (l1_req_wdata),
    .rsp_load      (rsp_load),
    .rsp_sel       (rsp_sel)
  );

  l0buf_store #(
    .SETS   (SETS),
    .WORDS  (WORDS),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .LINE_W (LINE_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (lk_addr[OFF_W +: IDX_W]),
    .lk_tag    (lk_addr[ADDR_W-1 -: TAG_W]),
    .lk_off    (lk_addr[OFF_W-1:0]),
    .lk_hit    (lk_hit),
    .lk_word   (lk_word),
    .wr_en     (wr_en),
    .wr_data   (cpu_req_wdata),
    .fill_en   (fill_en),
    .fill_idx  (lk_addr[OFF_W +: IDX_W]),
    .fill_tag  (lk_addr[ADDR_W-1 -: TAG_W]),
    .fill_line (l1_rsp_line),
    .inv_en    (l1_inv_valid),
    .inv_idx   (l1_inv_addr[OFF_W +: IDX_W]),
    .inv_tag   (l1_inv_addr[ADDR_W-1 -: TAG_W])
  );

  l0buf_rsp_mux #(
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .OFF_W  (OFF_W),
    .LINE_W (LINE_W)
  ) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rsp_load),
    .sel       (rsp_sel),
    .off       (lk_addr[OFF_W-1:0]),
    .buf_word  (lk_word),
    .l1_line   (l1_rsp_line),
    .rsp_valid (cpu_rsp_valid),
    .rsp_data  (cpu_rsp_rdata),
    .rsp_src   (cpu_rsp_from_buf)
  );

endmodule

// File: rtl/l0buf_checker.sv
module l0buf_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_req_valid,
  input logic cpu_req_ready,
  input logic cpu_req_we,
  input logic cpu_rsp_valid,
  input logic cpu_rsp_from_buf,
  input logic l1_req_valid,
  input logic l1_rsp_valid,
  input logic l1_rsp_hit,
  input logic lk_hit
);

  logic take;
  assign take = cpu_req_valid && cpu_req_ready;

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cpu_req_we && lk_hit |=> cpu_rsp_valid && cpu_rsp_from_buf); // R2
  AST_HIT_NO_L1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cpu_req_we && lk_hit |=> !l1_req_valid); // R2
  AST_MISS_TO_L1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !lk_hit |=> l1_req_valid); // R3
  AST_L1_MISS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    l1_rsp_valid && !l1_rsp_hit && !cpu_req_ready |=> cpu_rsp_valid); // R4
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req_valid |=> !l1_req_valid); // R9
  AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> cpu_req_ready); // R9
  AST_BUSY_ON_L1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !(lk_hit && !cpu_req_we) |=> !cpu_req_ready); // R9

endmodule

bind l0_hit_buffer l0buf_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cpu_req_valid    (cpu_req_valid),
  .cpu_req_ready    (cpu_req_ready),
  .cpu_req_we       (cpu_req_we),
  .cpu_rsp_valid    (cpu_rsp_valid),
  .cpu_rsp_from_buf (cpu_rsp_from_buf),
  .l1_req_valid     (l1_req_valid),
  .l1_rsp_valid     (l1_rsp_valid),
  .l1_rsp_hit       (l1_rsp_hit),
  .lk_hit           (lk_hit)
);

// File: tb/l0_hit_buffer_test.sv
module l0_hit_buffer_test;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int SETS   = 8;
  localparam int WORDS  = 4;
  localparam int OFF_W  = 2;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = 5;
  localparam int LINE_W = WORDS * DATA_W;
  localparam int MEM_N  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpu_req_valid;
  logic              cpu_req_ready;
  logic              cpu_req_we;
  logic [ADDR_W-1:0] cpu_req_addr;
  logic [DATA_W-1:0] cpu_req_wdata;
  logic              cpu_rsp_valid;
  logic [DATA_W-1:0] cpu_rsp_rdata;
  logic              cpu_rsp_from_buf;
  logic              l1_req_valid;
  logic              l1_req_we;
  logic [ADDR_W-1:0] l1_req_addr;
  logic [DATA_W-1:0] l1_req_wdata;
  logic              l1_rsp_valid;
  logic              l1_rsp_hit;
  logic [LINE_W-1:0] l1_rsp_line;
  logic              l1_inv_valid;
  logic [ADDR_W-1:0] l1_inv_addr;

  l0_hit_buffer #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SETS (SETS), .WORDS (WORDS)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .cpu_req_valid (cpu_req_valid), .cpu_req_ready (cpu_req_ready),
    .cpu_req_we (cpu_req_we), .cpu_req_addr (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata), .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_rdata (cpu_rsp_rdata), .cpu_rsp_from_buf (cpu_rsp_from_buf),
    .l1_req_valid (l1_req_valid), .l1_req_we (l1_req_we),
    .l1_req_addr (l1_req_addr), .l1_req_wdata (l1_req_wdata),
    .l1_rsp_valid (l1_rsp_valid), .l1_rsp_hit (l1_rsp_hit),
    .l1_rsp_line (l1_rsp_line), .l1_inv_valid (l1_inv_valid),
    .l1_inv_addr (l1_inv_addr)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DATA_W-1:0] mem [MEM_N];
  logic              l1v [SETS];
  logic [TAG_W-1:0]  l1t [SETS];
  int                l1_cnt = 0;
  logic              seen_we;
  logic [ADDR_W-1:0] seen_addr;
  logic [DATA_W-1:0] seen_wdata;
  bit                inv_with_rsp = 0;

  logic [DATA_W-1:0] r_data;
  logic              r_src;
  int                r_lat;
  int                r_l1d;
  logic              r_rdy1;

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
    return {TAG_W'(tag), IDX_W'(idx), OFF_W'(off)};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // L1 and main memory responder: fixed two-cycle answer, direct-mapped, evictions notified
  initial begin
    logic [IDX_W-1:0]  m_idx;
    logic [TAG_W-1:0]  m_tag;
    logic              m_hit;
    logic [ADDR_W-1:0] m_base;
    logic [LINE_W-1:0] m_line;
    l1_rsp_valid = 0; l1_rsp_hit = 0; l1_rsp_line = '0;
    l1_inv_valid = 0; l1_inv_addr = '0;
    for (int s = 0; s < SETS; s++) begin l1v[s] = 0; l1t[s] = '0; end
    forever begin
      @(negedge clk);
      if (rst_n && l1_req_valid) begin
        l1_cnt++;
        seen_we = l1_req_we; seen_addr = l1_req_addr; seen_wdata = l1_req_wdata;
        m_idx = l1_req_addr[OFF_W +: IDX_W];
        m_tag = l1_req_addr[ADDR_W-1 -: TAG_W];
        m_hit = l1v[m_idx] && (l1t[m_idx] == m_tag);
        if (!m_hit && l1v[m_idx]) begin
          l1_inv_valid = 1;
          l1_inv_addr  = {l1t[m_idx], m_idx, {OFF_W{1'b0}}};
        end
        if (!m_hit) begin l1v[m_idx] = 1; l1t[m_idx] = m_tag; end
        if (l1_req_we) mem[l1_req_addr] = l1_req_wdata;
        m_base = {l1_req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        for (int w = 0; w < WORDS; w++) m_line[w*DATA_W +: DATA_W] = mem[m_base + ADDR_W'(w)];
        @(negedge clk);
        l1_inv_valid = 0;
        l1_rsp_valid = 1; l1_rsp_hit = m_hit; l1_rsp_line = m_line;
        if (inv_with_rsp) begin
          l1_inv_valid = 1; l1_inv_addr = m_base; l1v[m_idx] = 0;
        end
        @(negedge clk);
        l1_rsp_valid = 0; l1_inv_valid = 0;
      end
    end
  end

  task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd);
    int c0;
    c0 = l1_cnt;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 0;
    r_rdy1 = cpu_req_ready;
    r_lat = 1;
    while (!cpu_rsp_valid && r_lat < 40) begin @(negedge clk); r_lat++; end
    r_data = cpu_rsp_rdata; r_src = cpu_rsp_from_buf; r_l1d = l1_cnt - c0;
    chk("R9", "response arrived", cpu_rsp_valid, 1);
  endtask

  task automatic inv_line(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    l1_inv_valid = 1; l1_inv_addr = a;
    if (l1v[a[OFF_W +: IDX_W]] && l1t[a[OFF_W +: IDX_W]] == a[ADDR_W-1 -: TAG_W])
      l1v[a[OFF_W +: IDX_W]] = 0;
    @(negedge clk);
    l1_inv_valid = 0;
  endtask

  task automatic t_reset_cold;
    logic [ADDR_W-1:0] a;
    a = mk(2, 1, 1);
    chk("R1", "ready after reset", cpu_req_ready, 1);
    chk("R1", "no response after reset", cpu_rsp_valid, 0);
    chk("R1", "no L1 request after reset", l1_req_valid, 0);
    access(0, a, '0);
    chk("R1", "cold read reaches L1", r_l1d, 1);
    chk("R4", "L1 miss source flag", r_src, 0);
    chk("R4", "L1 miss data", r_data, mem[a]);
    chk("R9", "busy while L1 pending", r_rdy1, 0);
  endtask

  task automatic t_fill;
    logic [ADDR_W-1:0] a;
    a = mk(2, 1, 1);
    access(0, a, '0);
    chk("R4", "line left out after L1 miss", r_l1d, 1);
    chk("R3", "fill source flag", r_src, 1);
    chk("R3", "fill data", r_data, mem[a]);
    access(0, a, '0);
    chk("R2", "hit latency", r_lat, 1);
    chk("R2", "hit makes no L1 request", r_l1d, 0);
    chk("R2", "hit source flag", r_src, 1);
    chk("R2", "hit data", r_data, mem[a]);
    access(0, mk(2, 1, 3), '0);
    chk("R8", "other word of line hits", r_l1d, 0);
    chk("R8", "other word data", r_data, mem[mk(2, 1, 3)]);
  endtask

  task automatic t_write_hit;
    logic [ADDR_W-1:0] a;
    a = mk(2, 1, 1);
    access(1, a, 32'hDEAD0001);
    chk("R5", "write-through request count", r_l1d, 1);
    chk("R5", "write-through is a write", seen_we, 1);
    chk("R5", "write-through address", seen_addr, a);
    chk("R5", "write-through data", seen_wdata, 32'hDEAD0001);
    chk("R5", "write hit source flag", r_src, 1);
    access(0, a, '0);
    chk("R5", "buffered word updated", r_data, 32'hDEAD0001);
    chk("R5", "read after write hit stays local", r_l1d, 0);
  endtask

  task automatic t_write_miss;
    logic [ADDR_W-1:0] b;
    logic [ADDR_W-1:0] c;
    b = mk(3, 2, 2);
    c = mk(4, 3, 1);
    access(0, mk(3, 2, 0), '0);
    access(1, b, 32'h0B0B0B0B);
    chk("R6", "write miss with L1 hit source", r_src, 1);
    chk("R6", "write miss forwarded", r_l1d, 1);
    access(0, b, '0);
    chk("R6", "written line buffered", r_l1d, 0);
    chk("R6", "merged word in buffer", r_data, 32'h0B0B0B0B);
    access(1, c, 32'h0C0C0C0C);
    chk("R6", "write miss with L1 miss source", r_src, 0);
    chk("R6", "L1 got the write", mem[c], 32'h0C0C0C0C);
    access(0, c, '0);
    chk("R6", "line not buffered after L1 miss", r_l1d, 1);
    chk("R6", "read back data", r_data, 32'h0C0C0C0C);
  endtask

  task automatic t_inv;
    logic [ADDR_W-1:0] a;
    a = mk(2, 1, 1);
    inv_line(mk(7, 1, 0));
    access(0, a, '0);
    chk("R7", "foreign tag leaves entry", r_l1d, 0);
    chk("R7", "entry data kept", r_data, 32'hDEAD0001);
    inv_line(mk(2, 1, 2));
    access(0, a, '0);
    chk("R7", "matching invalidate drops entry", r_l1d, 1);
    chk("R7", "data after invalidate", r_data, 32'hDEAD0001);
  endtask

  task automatic t_sets;
    for (int s = 0; s < SETS; s++) begin
      access(0, mk(9, s, 0), '0);
      access(0, mk(9, s, 0), '0);
    end
    for (int s = 0; s < SETS; s++) begin
      access(0, mk(9, s, 2), '0);
      chk("R8", "set holds own line", r_l1d, 0);
      chk("R8", "set data", r_data, mem[mk(9, s, 2)]);
    end
  endtask

  task automatic t_race;
    logic [ADDR_W-1:0] e;
    e = mk(12, 5, 3);
    access(0, e, '0);
    inv_with_rsp = 1;
    access(0, e, '0);
    inv_with_rsp = 0;
    chk("R10", "served during racing fill", r_data, mem[e]);
    access(0, e, '0);
    chk("R10", "invalidate wins over fill", r_l1d, 1);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 32'hC0DE0000 ^ (i * 32'h00010003);
    rst_n = 0;
    cpu_req_valid = 0; cpu_req_we = 0; cpu_req_addr = '0; cpu_req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_cold();
    t_fill();
    t_write_hit();
    t_write_miss();
    t_inv();
    t_sets();
    t_race();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule